// File: doc/BRIEF.md
# Pumped Register-File Port Adapter

This block lets one slow agent issue several register-file accesses per agent clock through a single physical port of a register file that runs on a faster clock. The fast clock is an integer multiple, `PUMP`, of the agent clock, and their rising edges line up. The agent presents `PUMP` read addresses and `PUMP` write requests, each made of an address, data and an enable, side by side. It raises `loadIn` for one fast cycle at the start of its own cycle.

Slot 0 goes straight through to the file in that load cycle. The other slots are parked in chained shift registers and reach the file one per fast cycle after it. Read results are collected serially into a parallel register. When `PUMP` is 1, the adapter reduces to wires between the agent and the file.

The register file itself is outside this block. The file is expected to return read data combinationally for the address on `fileRdAddr` and to commit a write at the fast clock edge that ends the cycle in which `fileWrEn` is high.

Top module: `pump_port_adapter`

## Requirements
- R1: Slot i of every agent bus sits at bits [i*W +: W], where W is the field width (ADDR_W, DATA_W, or 1 for `agentWrEn`). Slot i reaches the file in the i-th fast cycle of an access sequence. The load cycle counts as cycle 0.
- R2: In the cycle where `loadIn` is high, the file outputs carry slot 0 of the agent buses unchanged, with no register in the path.
- R3: In fast cycle k (1 ≤ k < PUMP) after a load, the file outputs carry slot k as it was captured in the load cycle. Agent inputs that change after the load cycle have no effect.
- R4: Outside the PUMP-cycle window that starts at a load, `fileWrEn`, `fileWrAddr`, `fileWrData` and `fileRdAddr` are all zero. A vacated stage therefore never writes.
- R5: In the last fast cycle of a sequence, `agentRdData` slot k holds the file's read result for slot k. Slots 0..PUMP-2 come from the capture register. Slot PUMP-1 is `fileRdData` itself, with no register in the path.
- R6: Slots are applied strictly in slot order. A read in slot k sees a write from slot j only when j < k. When two slots write the same address, the higher slot's value remains.
- R7: After reset, all shift stages are zero: the file outputs are zero, and `agentRdData` slots 0..PUMP-2 read zero.
- R8: With PUMP = 1, the file outputs equal the agent inputs and `agentRdData` equals `fileRdData`, combinationally.
- R9: A slot whose write enable is 0 leaves the file unchanged, whatever its address and data.
- R10: After the last cycle of a sequence, `agentRdData` slots 0..PUMP-2 hold their values until the next load.
- R11: A new load may come in the cycle right after the last slot of the previous sequence, so sequences can run back to back with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (register-file clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| loadIn | input | 1 | One-cycle strobe that starts an access sequence |
| agentRdAddr | input | PUMP*ADDR_W | Read address per slot |
| agentWrAddr | input | PUMP*ADDR_W | Write address per slot |
| agentWrData | input | PUMP*DATA_W | Write data per slot |
| agentWrEn | input | PUMP | Write enable per slot |
| agentRdData | output | PUMP*DATA_W | Read result per slot |
| fileRdAddr | output | ADDR_W | Read address to the file |
| fileWrAddr | output | ADDR_W | Write address to the file |
| fileWrData | output | DATA_W | Write data to the file |
| fileWrEn | output | 1 | Write enable to the file |
| fileRdData | input | DATA_W | Combinational read data from the file |

## Verification
A read and a write can fall in the same fast cycle, and a write can also fall in an earlier slot of the same sequence than a read of the same address. Directed sequences provoke both cases. In one, every read slot targets the address that one middle slot writes. In another, two slots write the same address and a later slot reads it back. Random sequences with dense address reuse add more such collisions. Each returned word is judged against a bench model that applies the slots one after another: the read first, then the write.

// File: rtl/pump_pkg.sv
package pump_pkg;
  // strobes from the sequencing control to the shift datapath
  typedef struct packed {
    logic load;     // parallel load of all stages, slot 0 passes through
    logic shift;    // advance input stages one step toward the file
    logic capture;  // shift the file's read result into the capture register
  } pumpStrobe_t;
endpackage

// File: rtl/pump_ctrl.sv
module pump_ctrl
  import pump_pkg::*;
#(
  parameter int PUMP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        loadIn,
  output pumpStrobe_t strb
);
  localparam int PH_W = $clog2(PUMP);
  localparam logic [PH_W-1:0] LAST = PH_W'(PUMP - 1);

  logic [PH_W-1:0] phase;
  logic            active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= '0;
      active <= 1'b0;
    end else if (loadIn) begin
      phase  <= PH_W'(1);
      active <= 1'b1;
    end else if (active) begin
      if (phase == LAST) begin
        phase  <= '0;
        active <= 1'b0;
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end

  always_comb begin
    strb.load    = loadIn;
    strb.shift   = active;
    // the last slot's result is never stored; it is read live
    strb.capture = loadIn | (active & (phase != LAST));
  end
endmodule

// File: rtl/pump_piso.sv
module pump_piso #(
  parameter int PUMP = 4,
  parameter int W    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            shift,
  input  logic [PUMP*W-1:0] parIn,
  output logic [W-1:0]    serOut
);
  localparam int STAGES = PUMP - 1;

  logic [STAGES*W-1:0]     stg;
  logic [STAGES*W-1:0]     nxt;
  logic [(STAGES+1)*W-1:0] ext;

  // zero word above the top stage feeds the vacated slot
  assign ext = {{W{1'b0}}, stg};

  always_comb begin
    for (int i = 0; i < STAGES; i++) begin
      if (load)
        nxt[i*W +: W] = parIn[(i+1)*W +: W];
      else if (shift)
        nxt[i*W +: W] = ext[(i+1)*W +: W];
      else
        nxt[i*W +: W] = stg[i*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stg <= '0;
    else        stg <= nxt;
  end

  assign serOut = load ? parIn[W-1:0] : stg[W-1:0];
endmodule

// File: rtl/pump_sipo.sv
module pump_sipo #(
  parameter int PUMP = 4,
  parameter int W    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  capture,
  input  logic [W-1:0]          serIn,
  output logic [(PUMP-1)*W-1:0] parOut
);
  localparam int STAGES = PUMP - 1;

  logic [STAGES*W-1:0]     q;
  logic [(STAGES+1)*W-1:0] ext;

  assign ext = {serIn, q};

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (capture) q <= ext[(STAGES+1)*W-1:W];
  end

  assign parOut = q;
endmodule

// File: rtl/pump_datapath.sv
module pump_datapath
  import pump_pkg::*;
#(
  parameter int PUMP   = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  pumpStrobe_t            strb,
  input  logic [PUMP*ADDR_W-1:0] agentRdAddr,
  input  logic [PUMP*ADDR_W-1:0] agentWrAddr,
  input  logic [PUMP*DATA_W-1:0] agentWrData,
  input  logic [PUMP-1:0]        agentWrEn,
  output logic [PUMP*DATA_W-1:0] agentRdData,
  output logic [ADDR_W-1:0]      fileRdAddr,
  output logic [ADDR_W-1:0]      fileWrAddr,
  output logic [DATA_W-1:0]      fileWrData,
  output logic                   fileWrEn,
  input  logic [DATA_W-1:0]      fileRdData
);
  logic [(PUMP-1)*DATA_W-1:0] heldRd;

  pump_piso #(.PUMP(PUMP), .W(ADDR_W)) u_rdAddr (
    .clk(clk), .rst_n(rst_n), .load(strb.load), .shift(strb.shift),
    .parIn(agentRdAddr), .serOut(fileRdAddr));

  pump_piso #(.PUMP(PUMP), .W(ADDR_W)) u_wrAddr (
    .clk(clk), .rst_n(rst_n), .load(strb.load), .shift(strb.shift),
    .parIn(agentWrAddr), .serOut(fileWrAddr));

  pump_piso #(.PUMP(PUMP), .W(DATA_W)) u_wrData (
    .clk(clk), .rst_n(rst_n), .load(strb.load), .shift(strb.shift),
    .parIn(agentWrData), .serOut(fileWrData));

  pump_piso #(.PUMP(PUMP), .W(1)) u_wrEn (
    .clk(clk), .rst_n(rst_n), .load(strb.load), .shift(strb.shift),
    .parIn(agentWrEn), .serOut(fileWrEn));

  pump_sipo #(.PUMP(PUMP), .W(DATA_W)) u_rdCap (
    .clk(clk), .rst_n(rst_n), .capture(strb.capture),
    .serIn(fileRdData), .parOut(heldRd));

  assign agentRdData = {fileRdData, heldRd};
endmodule

// File: rtl/pump_port_adapter.sv
module pump_port_adapter
  import pump_pkg::*;
#(
  parameter int PUMP   = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   loadIn,
  input  logic [PUMP*ADDR_W-1:0] agentRdAddr,
  input  logic [PUMP*ADDR_W-1:0] agentWrAddr,
  input  logic [PUMP*DATA_W-1:0] agentWrData,
  input  logic [PUMP-1:0]        agentWrEn,
  output logic [PUMP*DATA_W-1:0] agentRdData,
  output logic [ADDR_W-1:0]      fileRdAddr,
  output logic [ADDR_W-1:0]      fileWrAddr,
  output logic [DATA_W-1:0]      fileWrData,
  output logic                   fileWrEn,
  input  logic [DATA_W-1:0]      fileRdData
);
  if (PUMP == 1) begin : g_bypass
    assign fileRdAddr  = agentRdAddr;
    assign fileWrAddr  = agentWrAddr;
    assign fileWrData  = agentWrData;
    assign fileWrEn    = agentWrEn[0];
    assign agentRdData = fileRdData;
  end else begin : g_pumped
    pumpStrobe_t strb;

    pump_ctrl #(.PUMP(PUMP)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .loadIn(loadIn), .strb(strb));

    pump_datapath #(.PUMP(PUMP), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk(clk), .rst_n(rst_n), .strb(strb),
      .agentRdAddr(agentRdAddr), .agentWrAddr(agentWrAddr),
      .agentWrData(agentWrData), .agentWrEn(agentWrEn),
      .agentRdData(agentRdData),
      .fileRdAddr(fileRdAddr), .fileWrAddr(fileWrAddr),
      .fileWrData(fileWrData), .fileWrEn(fileWrEn),
      .fileRdData(fileRdData));
  end
endmodule

// File: rtl/pump_port_adapter_chk.sv
module pump_port_adapter_chk #(
  parameter int PUMP   = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   loadIn,
  input logic [PUMP*ADDR_W-1:0] agentRdAddr,
  input logic [PUMP*ADDR_W-1:0] agentWrAddr,
  input logic [PUMP*DATA_W-1:0] agentWrData,
  input logic [PUMP-1:0]        agentWrEn,
  input logic [PUMP*DATA_W-1:0] agentRdData,
  input logic [ADDR_W-1:0]      fileRdAddr,
  input logic [ADDR_W-1:0]      fileWrAddr,
  input logic [DATA_W-1:0]      fileWrData,
  input logic                   fileWrEn,
  input logic [DATA_W-1:0]      fileRdData
);
  localparam int CW = $clog2(PUMP + 1);

  // cycles since the last load; PUMP means idle
  logic [CW-1:0] sinceLoad;
  always_ff @(posedge clk) begin
    if (!rst_n)                      sinceLoad <= CW'(PUMP);
    else if (loadIn)                 sinceLoad <= CW'(1);
    else if (sinceLoad < CW'(PUMP))  sinceLoad <= sinceLoad + CW'(1);
  end

  if (PUMP > 1) begin : g_pumped
    p_slot0_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      loadIn |-> (fileRdAddr == agentRdAddr[ADDR_W-1:0] &&
                  fileWrAddr == agentWrAddr[ADDR_W-1:0] &&
                  fileWrData == agentWrData[DATA_W-1:0] &&
                  fileWrEn   == agentWrEn[0]));

    p_slot1_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
      loadIn |=> (fileRdAddr == $past(agentRdAddr[2*ADDR_W-1:ADDR_W]) &&
                  fileWrEn   == $past(agentWrEn[1])));

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!loadIn && sinceLoad == CW'(PUMP)) |->
        (!fileWrEn && fileWrAddr == '0 && fileRdAddr == '0 && fileWrData == '0));

    p_last_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!loadIn && sinceLoad == CW'(PUMP-1)) |->
        (agentRdData[PUMP*DATA_W-1 -: DATA_W] == fileRdData));

    p_held_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!loadIn && sinceLoad == CW'(PUMP)) |->
        $stable(agentRdData[(PUMP-1)*DATA_W-1:0]));

    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      loadIn |-> (sinceLoad == CW'(PUMP)));
  end else begin : g_bypass
    p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fileWrEn == agentWrEn[0] && fileRdAddr == agentRdAddr &&
       agentRdData == fileRdData));
  end
endmodule

bind pump_port_adapter pump_port_adapter_chk #(
  .PUMP(PUMP), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/pump_port_adapter_bench.sv
`timescale 1ns/1ps
module pump_port_adapter_bench;
  localparam int N     = 4;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // main DUT
  logic            loadIn = 1'b0;
  logic [N*AW-1:0] agentRdAddr = '0, agentWrAddr = '0;
  logic [N*DW-1:0] agentWrData = '0;
  logic [N-1:0]    agentWrEn = '0;
  logic [N*DW-1:0] agentRdData;
  logic [AW-1:0]   fileRdAddr, fileWrAddr;
  logic [DW-1:0]   fileWrData, fileRdData;
  logic            fileWrEn;

  pump_port_adapter #(.PUMP(N), .ADDR_W(AW), .DATA_W(DW)) u_pump_port_adapter (
    .clk(clk), .rst_n(rst_n), .loadIn(loadIn),
    .agentRdAddr(agentRdAddr), .agentWrAddr(agentWrAddr),
    .agentWrData(agentWrData), .agentWrEn(agentWrEn),
    .agentRdData(agentRdData),
    .fileRdAddr(fileRdAddr), .fileWrAddr(fileWrAddr),
    .fileWrData(fileWrData), .fileWrEn(fileWrEn), .fileRdData(fileRdData));

  // bypass DUT
  logic          bLoad = 1'b0;
  logic [AW-1:0] bRdAddr = '0, bWrAddr = '0, bFileRdAddr, bFileWrAddr;
  logic [DW-1:0] bWrData = '0, bRdData, bFileWrData, bFileRdData = '0;
  logic [0:0]    bWrEn = '0;
  logic          bFileWrEn;

  pump_port_adapter #(.PUMP(1), .ADDR_W(AW), .DATA_W(DW)) u_pump_port_adapter_bypass (
    .clk(clk), .rst_n(rst_n), .loadIn(bLoad),
    .agentRdAddr(bRdAddr), .agentWrAddr(bWrAddr),
    .agentWrData(bWrData), .agentWrEn(bWrEn),
    .agentRdData(bRdData),
    .fileRdAddr(bFileRdAddr), .fileWrAddr(bFileWrAddr),
    .fileWrData(bFileWrData), .fileWrEn(bFileWrEn), .fileRdData(bFileRdData));

  // behavioural register file: combinational read, write at edge
  logic [DW-1:0] mem [DEPTH];
  function automatic logic [DW-1:0] seedVal(int i);
    return DW'(i * 7 + 1);
  endfunction
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= seedVal(i);
    end else if (fileWrEn) begin
      mem[fileWrAddr] <= fileWrData;
    end
  end
  assign fileRdData = mem[fileRdAddr];

  // bench reference model
  logic [DW-1:0] refMem [DEPTH];
  logic [AW-1:0] ra [N];
  logic [AW-1:0] wa [N];
  logic [DW-1:0] wd [N];
  logic          we [N];
  logic [DW-1:0] expRd [N];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // slots applied in order: read first, then write (R6)
  task automatic modelTxn();
    for (int k = 0; k < N; k++) begin
      expRd[k] = refMem[ra[k]];
      if (we[k]) refMem[wa[k]] = wd[k];
    end
  endtask

  task automatic runTxn();
    modelTxn();
    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      agentRdAddr[k*AW +: AW] = ra[k];
      agentWrAddr[k*AW +: AW] = wa[k];
      agentWrData[k*DW +: DW] = wd[k];
      agentWrEn[k]            = we[k];
    end
    loadIn = 1'b1;
    #1;
    check(fileRdAddr == ra[0] && fileWrAddr == wa[0] && fileWrData == wd[0] &&
          fileWrEn == we[0], "R2 slot0 pass",
          {fileWrEn, fileWrData, fileWrAddr, fileRdAddr},
          {we[0], wd[0], wa[0], ra[0]});
    for (int k = 1; k < N; k++) begin
      @(negedge clk);
      if (k == 1) begin
        loadIn      = 1'b0;
        agentRdAddr = N*AW'($urandom);
        agentWrAddr = N*AW'($urandom);
        agentWrData = N*DW'($urandom);
        agentWrEn   = N'($urandom);
      end
      #1;
      check(fileRdAddr == ra[k] && fileWrAddr == wa[k] && fileWrData == wd[k] &&
            fileWrEn == we[k], "R3 slot k drive",
            {fileWrEn, fileWrData, fileWrAddr, fileRdAddr},
            {we[k], wd[k], wa[k], ra[k]});
    end
    for (int k = 0; k < N; k++)
      check(agentRdData[k*DW +: DW] == expRd[k], "R5 R6 read slot",
            agentRdData[k*DW +: DW], expRd[k]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      check(!fileWrEn && fileWrAddr == '0 && fileRdAddr == '0 && fileWrData == '0,
            "R4 idle quiet", {fileWrEn, fileWrData, fileWrAddr, fileRdAddr}, 0);
      for (int k = 0; k < N-1; k++)
        check(agentRdData[k*DW +: DW] == expRd[k], "R10 held read",
              agentRdData[k*DW +: DW], expRd[k]);
    end
  endtask

  task automatic readSweep();
    for (int b = 0; b < DEPTH; b += N) begin
      for (int k = 0; k < N; k++) begin
        ra[k] = AW'(b + k); wa[k] = AW'(b + k); wd[k] = 8'hEE; we[k] = 1'b0;
      end
      runTxn();
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) refMem[i] = seedVal(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R7: reset state
    check(!fileWrEn && fileWrAddr == '0 && fileRdAddr == '0 && fileWrData == '0,
          "R7 reset file side", {fileWrEn, fileWrData, fileWrAddr, fileRdAddr}, 0);
    check(agentRdData == {seedVal(0), {(N-1)*DW{1'b0}}}, "R7 reset read side",
          agentRdData, {seedVal(0), {(N-1)*DW{1'b0}}});

    // R6: read-around-write on one address
    for (int k = 0; k < N; k++) begin ra[k] = 4'd5; wa[k] = 4'd5; wd[k] = 8'h10 + 8'(k); we[k] = 1'b0; end
    we[1] = 1'b1; wd[1] = 8'hAA;
    runTxn();
    idle(2);

    // R6: two writes to one address, later slot wins
    for (int k = 0; k < N; k++) begin ra[k] = 4'd9; wa[k] = 4'd9; wd[k] = 8'h30 + 8'(k); we[k] = 1'b0; end
    we[0] = 1'b1; we[2] = 1'b1;
    runTxn();
    // R11: back-to-back, reads the winner
    for (int k = 0; k < N; k++) begin ra[k] = AW'(9 - k); wa[k] = 4'd0; wd[k] = 8'hFF; we[k] = 1'b0; end
    runTxn();
    idle(1);

    // R9: enables low with live address and data
    for (int k = 0; k < N; k++) begin ra[k] = AW'(k); wa[k] = AW'(k + 2); wd[k] = 8'h5A; we[k] = 1'b0; end
    runTxn();
    idle(1);

    // random mix, dense address reuse (R1 R6 R11)
    for (int t = 0; t < 40; t++) begin
      for (int k = 0; k < N; k++) begin
        ra[k] = AW'($urandom % 6);
        wa[k] = AW'($urandom % 6);
        wd[k] = DW'($urandom);
        we[k] = 1'($urandom);
      end
      runTxn();
      idle(int'($urandom % 3));
    end

    // R9: final contents match the model
    readSweep();
    idle(2);

    // R8: bypass is combinational
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      bRdAddr = AW'($urandom); bWrAddr = AW'($urandom);
      bWrData = DW'($urandom); bWrEn = 1'($urandom); bFileRdData = DW'($urandom);
      bLoad = 1'($urandom);
      #1;
      check(bFileRdAddr == bRdAddr && bFileWrAddr == bWrAddr && bFileWrData == bWrData &&
            bFileWrEn == bWrEn[0] && bRdData == bFileRdData, "R8 bypass",
            {bFileWrEn, bFileWrData, bFileWrAddr, bFileRdAddr, bRdData},
            {bWrEn[0], bWrData, bWrAddr, bRdAddr, bFileRdData});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule